// File: doc/BRIEF.md
# Atomic Fetch-and-Op ALU

This block is the read-modify-write datapath that sits next to a cache or memory controller and executes one atomic operation per request. The sequencer that reads memory hands it the current value at the target address, the register operands and, for the forms that need it, the neighbouring memory word. One clock later the block answers with the value to write back, whether to write at all (and whether the neighbour is written too), and the value to return to the register file.

A 5-bit function code and a load/store flag choose the operation. A 2-bit size code chooses the operand width. Arithmetic, comparisons and the chosen bound all work on the selected width only. Every result leaves the block zero-extended to 64 bits, so sub-word forms behave exactly like their full-width counterparts on a narrow field. Function codes that do not apply to the requested form are reported as illegal and have no side effect.

Top module: `atomic_rmw_alu`

## Requirements
- R1: `req_width` selects the operand width: 0 means 8 bits, 1 means 16, 2 means 32 and 3 means 64. Only the low bits of each input at that width take part. `wr_data` and `ret_data` are zero above that width.
- R2: On the load form (`req_store`=0), codes 00000, 00001, 00010 and 00011 write old+operand (wrapping at the width), old XOR operand, old OR operand and old AND operand respectively. Each returns the old value.
- R3: Codes 00100, 00101, 00110 and 00111 write the larger unsigned, the larger signed, the smaller unsigned and the smaller signed of old and `op_a` respectively. Signedness is taken at the selected width. The load form returns the old value.
- R4: Code 01000 on the load form writes `op_a` and returns the old value.
- R5: Code 10000 on the load form writes `op_b` only when old differs from `op_a` at the selected width. It returns the old value in both cases.
- R6: Code 11000 on the load form treats `mem_adj` as the bound. When old differs from the bound, it writes old+1 and returns old. Otherwise it does not write and returns a value with only bit (width-1) set.
- R7: Code 11001 on the load form writes old+1 and returns old when old equals `mem_adj`, and otherwise behaves like the refused case of R6. Code 11100 writes old-1 and returns old when old differs from `mem_adj`, and otherwise behaves like the refused case of R6.
- R8: On the store form (`req_store`=1), codes 00000 to 00111 write the same value as on the load form. `ret_valid` stays 0 and `ret_data` stays 0.
- R9: Code 11000 on the store form, when old equals `mem_adj` at the width, asserts `wr_en` and `wr_pair` and writes `op_a` to both words. Otherwise nothing is written. `ret_valid` stays 0.
- R10: Any other code/form combination asserts `illegal_op`, with `wr_en`, `wr_pair` and `ret_valid` at 0 and both data outputs at 0. Such combinations include codes 01000 and 10000 on the store form, and any unlisted code.
- R11: All outputs are registered. The response to a request accepted at a rising edge appears after that edge and is marked by `rsp_valid`. An active-low reset clears every output to 0.
- R12: When no request was accepted at the last edge, `rsp_valid`, `wr_en`, `wr_pair`, `ret_valid` and `illegal_op` are all 0. When no write takes place, `wr_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation present this cycle |
| req_store | input | 1 | 1 = store form (no return value), 0 = load form |
| req_func | input | 5 | Function code |
| req_width | input | 2 | Size code, 0..3 = 8/16/32/64 bits |
| mem_old | input | 64 | Current memory value at the target address |
| op_a | input | 64 | First operand (addend, compare value, swap or twin value) |
| op_b | input | 64 | Second operand (replacement for compare-and-swap-not-equal) |
| mem_adj | input | 64 | Neighbouring memory word used as bound or twin |
| rsp_valid | output | 1 | Response present |
| illegal_op | output | 1 | Function/form combination not supported |
| wr_en | output | 1 | Write `wr_data` to the target word |
| wr_pair | output | 1 | Also write `wr_data` to the neighbouring word |
| wr_data | output | 64 | New memory value, zero-extended |
| ret_valid | output | 1 | `ret_data` goes to the register file |
| ret_data | output | 64 | Returned value, zero-extended |

## Verification
The block has one register stage, so every output belongs to the request accepted at the previous rising edge, and a request that is withdrawn at the next falling edge leaves a single response cycle. The bench drives each request at a falling edge and samples the full response vector at the following falling edge, one edge after acceptance. It then idles one cycle, so no response overlaps the next stimulus. Expected values for the sub-word, signed, wrap-around and refused-bound cases are worked out by hand and written as literals in each scenario task.

// File: rtl/atom_rmw_pkg.sv
package atom_rmw_pkg;

  parameter int unsigned XLEN   = 64;
  parameter int unsigned FUNC_W = 5;
  parameter int unsigned SIZE_W = 2;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [FUNC_W-1:0] func_t;
  typedef logic [SIZE_W-1:0] size_t;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD  = 5'b00000,
    FN_XOR  = 5'b00001,
    FN_OR   = 5'b00010,
    FN_AND  = 5'b00011,
    FN_MAXU = 5'b00100,
    FN_MAXS = 5'b00101,
    FN_MINU = 5'b00110,
    FN_MINS = 5'b00111,
    FN_SWAP = 5'b01000,
    FN_CSNE = 5'b10000,
    FN_INCB = 5'b11000,
    FN_INCE = 5'b11001,
    FN_DECB = 5'b11100
  } afn_e;

  typedef enum logic [2:0] {
    CL_ARITH,
    CL_SWAP,
    CL_CSNE,
    CL_BOUND,
    CL_TWIN,
    CL_BAD
  } op_class_e;

  function automatic int unsigned lane_bits(size_t wc);
    return 8 << wc;
  endfunction

  function automatic word_t lane_mask(size_t wc);
    if (lane_bits(wc) >= XLEN) return '1;
    return (word_t'(1) << lane_bits(wc)) - word_t'(1);
  endfunction

  function automatic word_t lane_msb(size_t wc);
    return word_t'(1) << (lane_bits(wc) - 1);
  endfunction

  function automatic word_t fit(word_t v, size_t wc);
    return v & lane_mask(wc);
  endfunction

  function automatic word_t sext(word_t v, size_t wc);
    return fit(v, wc) | (((v & lane_msb(wc)) != '0) ? ~lane_mask(wc) : '0);
  endfunction

  function automatic logic lt_signed(word_t a, word_t b, size_t wc);
    return $signed(sext(a, wc)) < $signed(sext(b, wc));
  endfunction

  function automatic logic lt_unsigned(word_t a, word_t b, size_t wc);
    return fit(a, wc) < fit(b, wc);
  endfunction

endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_rmw_pkg::*;
(
  input  func_t     func,
  input  logic      is_store,
  output op_class_e cls
);

  always_comb begin
    cls = CL_BAD;
    if (func[4:3] == 2'b00) begin
      cls = CL_ARITH;
    end else if (is_store) begin
      if (func == FN_INCB) cls = CL_TWIN;
    end else begin
      case (func)
        FN_SWAP:                   cls = CL_SWAP;
        FN_CSNE:                   cls = CL_CSNE;
        FN_INCB, FN_INCE, FN_DECB: cls = CL_BOUND;
        default:                   cls = CL_BAD;
      endcase
    end
  end

endmodule

// File: rtl/atom_logic_unit.sv
module atom_logic_unit
  import atom_rmw_pkg::*;
(
  input  logic [2:0] sel,
  input  size_t      wc,
  input  word_t      old_v,
  input  word_t      opnd,
  output word_t      result
);

  word_t raw;

  always_comb begin
    case (sel)
      3'd0:    raw = old_v + opnd;
      3'd1:    raw = old_v ^ opnd;
      3'd2:    raw = old_v | opnd;
      3'd3:    raw = old_v & opnd;
      3'd4:    raw = lt_unsigned(old_v, opnd, wc) ? opnd  : old_v;
      3'd5:    raw = lt_signed(old_v, opnd, wc)   ? opnd  : old_v;
      3'd6:    raw = lt_unsigned(old_v, opnd, wc) ? old_v : opnd;
      default: raw = lt_signed(old_v, opnd, wc)   ? old_v : opnd;
    endcase
    result = fit(raw, wc);
  end

endmodule

// File: rtl/atom_bound_unit.sv
module atom_bound_unit
  import atom_rmw_pkg::*;
(
  input  size_t wc,
  input  logic  want_equal,
  input  logic  step_down,
  input  word_t old_v,
  input  word_t bound_v,
  output logic  go,
  output word_t next_v,
  output word_t give_v
);

  logic same;

  always_comb begin
    same   = fit(old_v, wc) == fit(bound_v, wc);
    go     = want_equal ? same : !same;
    next_v = fit(step_down ? (old_v - word_t'(1)) : (old_v + word_t'(1)), wc);
    give_v = go ? fit(old_v, wc) : lane_msb(wc);
  end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atom_rmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [4:0]  req_func,
  input  logic [1:0]  req_width,
  input  logic [63:0] mem_old,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [63:0] mem_adj,
  output logic        rsp_valid,
  output logic        illegal_op,
  output logic        wr_en,
  output logic        wr_pair,
  output logic [63:0] wr_data,
  output logic        ret_valid,
  output logic [63:0] ret_data
);

  op_class_e cls;
  word_t     lu_res;
  logic      bnd_go;
  word_t     bnd_next;
  word_t     bnd_give;

  logic  n_ill, n_wr, n_pair, n_rv;
  word_t n_wd, n_rd;
  size_t wc_q;
  logic  st_q;

  // event wires for the checks
  logic  twin_match;
  logic  csne_differs;

  atom_decode u_dec (
    .func     (req_func),
    .is_store (req_store),
    .cls      (cls)
  );

  atom_logic_unit u_lu (
    .sel    (req_func[2:0]),
    .wc     (req_width),
    .old_v  (mem_old),
    .opnd   (op_a),
    .result (lu_res)
  );

  atom_bound_unit u_bnd (
    .wc         (req_width),
    .want_equal (req_func[0]),
    .step_down  (req_func[2]),
    .old_v      (mem_old),
    .bound_v    (mem_adj),
    .go         (bnd_go),
    .next_v     (bnd_next),
    .give_v     (bnd_give)
  );

  assign twin_match   = fit(mem_old, req_width) == fit(mem_adj, req_width);
  assign csne_differs = fit(mem_old, req_width) != fit(op_a, req_width);

  always_comb begin
    n_ill  = 1'b0;
    n_wr   = 1'b0;
    n_pair = 1'b0;
    n_rv   = 1'b0;
    n_wd   = '0;
    n_rd   = '0;
    if (req_valid) begin
      case (cls)
        CL_ARITH: begin
          n_wr = 1'b1;
          n_wd = lu_res;
          n_rv = !req_store;
          n_rd = req_store ? '0 : fit(mem_old, req_width);
        end
        CL_SWAP: begin
          n_wr = 1'b1;
          n_wd = fit(op_a, req_width);
          n_rv = 1'b1;
          n_rd = fit(mem_old, req_width);
        end
        CL_CSNE: begin
          n_wr = csne_differs;
          n_wd = csne_differs ? fit(op_b, req_width) : '0;
          n_rv = 1'b1;
          n_rd = fit(mem_old, req_width);
        end
        CL_BOUND: begin
          n_wr = bnd_go;
          n_wd = bnd_go ? bnd_next : '0;
          n_rv = 1'b1;
          n_rd = bnd_give;
        end
        CL_TWIN: begin
          n_wr   = twin_match;
          n_pair = twin_match;
          n_wd   = twin_match ? fit(op_a, req_width) : '0;
        end
        default: n_ill = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      illegal_op <= 1'b0;
      wr_en      <= 1'b0;
      wr_pair    <= 1'b0;
      wr_data    <= '0;
      ret_valid  <= 1'b0;
      ret_data   <= '0;
      wc_q       <= '0;
      st_q       <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      illegal_op <= n_ill;
      wr_en      <= n_wr;
      wr_pair    <= n_pair;
      wr_data    <= n_wd;
      ret_valid  <= n_rv;
      ret_data   <= n_rd;
      wc_q       <= req_width;
      st_q       <= req_store;
    end
  end

  AST_WRITE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data & ~lane_mask(wc_q)) == '0); // R1
  AST_RETURN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_data & ~lane_mask(wc_q)) == '0); // R1
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && st_q) |-> !ret_valid); // R8
  AST_PAIR_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pair |-> (wr_en && st_q)); // R9
  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!wr_en && !ret_valid && wr_data == '0)); // R10
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!wr_en && !ret_valid && !illegal_op && !wr_pair)); // R12
  AST_NO_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_data == '0); // R12

endmodule

// File: tb/atomic_rmw_alu_test.sv
module atomic_rmw_alu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store;
  logic [4:0]  req_func;
  logic [1:0]  req_width;
  logic [63:0] mem_old, op_a, op_b, mem_adj;
  logic        rsp_valid, illegal_op, wr_en, wr_pair, ret_valid;
  logic [63:0] wr_data, ret_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  atomic_rmw_alu uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_func(req_func), .req_width(req_width), .mem_old(mem_old),
    .op_a(op_a), .op_b(op_b), .mem_adj(mem_adj), .rsp_valid(rsp_valid),
    .illegal_op(illegal_op), .wr_en(wr_en), .wr_pair(wr_pair),
    .wr_data(wr_data), .ret_valid(ret_valid), .ret_data(ret_data)
  );

  task automatic check(string tag, logic [132:0] act, logic [132:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [132:0] pack_out();
    return {rsp_valid, illegal_op, wr_en, wr_pair, ret_valid, wr_data, ret_data};
  endfunction

  // drive at a falling edge, response sampled one falling edge later
  task automatic run(string tag, logic st, logic [4:0] fn, logic [1:0] wc,
                     logic [63:0] old, logic [63:0] a, logic [63:0] b, logic [63:0] adj,
                     logic ill, logic we, logic pr, logic [63:0] wd,
                     logic rv, logic [63:0] rd);
    req_valid = 1'b1; req_store = st; req_func = fn; req_width = wc;
    mem_old = old; op_a = a; op_b = b; mem_adj = adj;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, pack_out(), {1'b1, ill, we, pr, rv, wd, rd});
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 reset", pack_out(), '0);
  endtask

  task automatic t_logic();
    run("R2 add8 wrap", 0, 5'b00000, 2'd0, 64'h12345678_9ABCDEF0, 64'h25, 0, 0,
        0, 1, 0, 64'h15, 1, 64'hF0);
    run("R2 xor16", 0, 5'b00001, 2'd1, 64'h1234, 64'hFFFF, 0, 0,
        0, 1, 0, 64'hEDCB, 1, 64'h1234);
    run("R2 or32", 0, 5'b00010, 2'd2, 64'hAAAA0000_0000F0F0, 64'h0F0F0000, 0, 0,
        0, 1, 0, 64'h0F0FF0F0, 1, 64'h0000F0F0);
    run("R2 and64", 0, 5'b00011, 2'd3, 64'hFF00FF00_FF00FF00, 64'h0F0F0F0F_0F0F0F0F, 0, 0,
        0, 1, 0, 64'h0F000F00_0F000F00, 1, 64'hFF00FF00_FF00FF00);
    run("R1 add64 wrap", 0, 5'b00000, 2'd3, 64'hFFFFFFFF_FFFFFFFF, 64'h2, 0, 0,
        0, 1, 0, 64'h1, 1, 64'hFFFFFFFF_FFFFFFFF);
  endtask

  task automatic t_minmax();
    run("R3 maxu8", 0, 5'b00100, 2'd0, 64'h80, 64'h7F, 0, 0, 0, 1, 0, 64'h80, 1, 64'h80);
    run("R3 maxs8", 0, 5'b00101, 2'd0, 64'h80, 64'h7F, 0, 0, 0, 1, 0, 64'h7F, 1, 64'h80);
    run("R3 minu16", 0, 5'b00110, 2'd1, 64'h8000, 64'h1, 0, 0, 0, 1, 0, 64'h1, 1, 64'h8000);
    run("R3 mins16", 0, 5'b00111, 2'd1, 64'h8000, 64'h1, 0, 0, 0, 1, 0, 64'h8000, 1, 64'h8000);
    run("R3 mins32", 0, 5'b00111, 2'd2, 64'hFFFFFFFF, 64'h5, 0, 0,
        0, 1, 0, 64'hFFFFFFFF, 1, 64'hFFFFFFFF);
    run("R3 maxs64", 0, 5'b00101, 2'd3, 64'h80000000_00000000, 64'h1, 0, 0,
        0, 1, 0, 64'h1, 1, 64'h80000000_00000000);
  endtask

  task automatic t_swap();
    run("R4 swap32", 0, 5'b01000, 2'd2, 64'h11112222_33334444, 64'hDEADBEEF_CAFEF00D, 0, 0,
        0, 1, 0, 64'hCAFEF00D, 1, 64'h33334444);
  endtask

  task automatic t_csne();
    run("R5 csne equal", 0, 5'b10000, 2'd1, 64'h55AA, 64'h55AA, 64'h1111, 0,
        0, 0, 0, 64'h0, 1, 64'h55AA);
    run("R5 csne differ", 0, 5'b10000, 2'd1, 64'h55AA, 64'h1234, 64'h1111, 0,
        0, 1, 0, 64'h1111, 1, 64'h55AA);
    run("R5 csne equal at width", 0, 5'b10000, 2'd1, 64'hABCD55AA, 64'h777755AA, 64'h1111, 0,
        0, 0, 0, 64'h0, 1, 64'h55AA);
  endtask

  task automatic t_bounded();
    run("R6 incb go", 0, 5'b11000, 2'd0, 64'h10, 0, 0, 64'h20, 0, 1, 0, 64'h11, 1, 64'h10);
    run("R6 incb at bound", 0, 5'b11000, 2'd0, 64'h20, 0, 0, 64'h20, 0, 0, 0, 64'h0, 1, 64'h80);
    run("R6 incb wrap8", 0, 5'b11000, 2'd0, 64'hFF, 0, 0, 64'h0, 0, 1, 0, 64'h0, 1, 64'hFF);
    run("R7 ince equal", 0, 5'b11001, 2'd1, 64'h42, 0, 0, 64'h42, 0, 1, 0, 64'h43, 1, 64'h42);
    run("R7 ince differ", 0, 5'b11001, 2'd1, 64'h42, 0, 0, 64'h43, 0, 0, 0, 64'h0, 1, 64'h8000);
    run("R7 decb go", 0, 5'b11100, 2'd3, 64'h5, 0, 0, 64'h1, 0, 1, 0, 64'h4, 1, 64'h5);
    run("R7 decb at bound", 0, 5'b11100, 2'd3, 64'h1, 0, 0, 64'h1,
        0, 0, 0, 64'h0, 1, 64'h80000000_00000000);
  endtask

  task automatic t_store();
    run("R8 store add16", 1, 5'b00000, 2'd1, 64'h00FF, 64'h1, 0, 0, 0, 1, 0, 64'h0100, 0, 64'h0);
    run("R8 store mins8", 1, 5'b00111, 2'd0, 64'h05, 64'hFE, 0, 0, 0, 1, 0, 64'hFE, 0, 64'h0);
  endtask

  task automatic t_twin();
    run("R9 twin match", 1, 5'b11000, 2'd2, 64'h7, 64'h99, 0, 64'h7, 0, 1, 1, 64'h99, 0, 64'h0);
    run("R9 twin differ", 1, 5'b11000, 2'd2, 64'h7, 64'h99, 0, 64'h8, 0, 0, 0, 64'h0, 0, 64'h0);
  endtask

  task automatic t_illegal();
    run("R10 load 01001", 0, 5'b01001, 2'd3, 64'h5, 64'h6, 0, 0, 1, 0, 0, 64'h0, 0, 64'h0);
    run("R10 store swap", 1, 5'b01000, 2'd3, 64'h5, 64'h6, 0, 0, 1, 0, 0, 64'h0, 0, 64'h0);
    run("R10 store csne", 1, 5'b10000, 2'd3, 64'h5, 64'h6, 64'h7, 0, 1, 0, 0, 64'h0, 0, 64'h0);
    run("R10 load 11101", 0, 5'b11101, 2'd0, 64'h5, 0, 0, 64'h9, 1, 0, 0, 64'h0, 0, 64'h0);
  endtask

  task automatic t_idle();
    req_valid = 1'b0; req_store = 1'b0; req_func = 5'b00000; req_width = 2'd3;
    mem_old = 64'h1234; op_a = 64'h1;
    @(negedge clk);
    check("R12 idle", pack_out(), '0);
  endtask

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_func = '0; req_width = '0;
    mem_old = '0; op_a = '0; op_b = '0; mem_adj = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_logic();
    t_minmax();
    t_swap();
    t_csne();
    t_bounded();
    t_store();
    t_twin();
    t_illegal();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule